// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This controller lets software on any core raise a doorbell interrupt at any other core, or at itself, and lets the receiving core acknowledge it. Every target core owns a word of pending state. Each message type holds a fixed bit in that word, and the message bits are spread four bit positions apart. The level of each pending bit drives a dedicated interrupt line toward its core, so each message type has its own line per core.

Software raises a message by writing a one at the message's bit into the target core's raise register. It acknowledges the message by writing the same pattern into that core's acknowledge register. Several requesters reach the controller in parallel, one simple 32-bit register port each: address, write enable, write data, and combinational read data. All requests that arrive in one cycle are merged. When a raise and an acknowledge hit the same bit in one cycle, the raise wins, so no doorbell is lost.

Top module: `ipi_ctrl`

## Requirements
- R1: After a synchronous reset, every pending bit is zero, every interrupt line is low, and every read returns zero.
- R2: A write to the raise register of core c, at byte address 0x70 + 4*c, sets pending message m of core c for each m whose write-data bit 4*m is one. Bits written as zero leave the pending state unchanged.
- R3: A write to the acknowledge register of core c, at byte address 0x80 + 4*c, clears pending message m of core c for each m whose write-data bit 4*m is one. Bits written as zero leave the pending state unchanged.
- R4: Reading address 0x70 + 4*c returns core c's pending message m at bit 4*m, with every other bit zero. Every other address reads as zero, including the acknowledge addresses.
- R5: Line irq_out[c*NUM_MSGS + m] equals pending message m of core c. It changes in the cycle after the clock edge that captured the write.
- R6: When one cycle carries both a raise and an acknowledge of the same bit, the bit ends up set.
- R7: Writes from different ports in the same cycle take effect together: raises combine by OR and acknowledges by OR.
- R8: A write is ignored when it targets a core index at or above NUM_CORES, an address that is not a multiple of four, or an address outside both register banks.
- R9: Write-data bits at positions other than 4*m, for m below NUM_MSGS, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address per requester port, port p in slice p |
| bus_we | input | NUM_PORTS | Write enable per requester port |
| bus_wdata | input | NUM_PORTS*32 | Write data per requester port |
| bus_rdata | output | NUM_PORTS*32 | Combinational read data per requester port |
| irq_out | output | NUM_CORES*NUM_MSGS | Interrupt level, index c*NUM_MSGS + m |

## Verification
The assertions assume the write enables are held low during reset, so that no request is pending at the first edge after reset. They also treat every address and data pattern as legal, and rely on the decoder to discard requests that match nothing. The stimulus keeps the write enables low throughout reset. After reset it mixes addresses from both banks with out-of-range core indices, unaligned offsets and arbitrary bytes, so the ignore paths are exercised alongside the real ones. Write data alternates between sparse message patterns and fully random words, so the bits between message positions are also driven.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int BUS_DW     = 32;
    localparam int MSG_STRIDE = 4;
    localparam int MAX_CORES  = 4;
    localparam int MAX_MSGS   = 7;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_RAISE = 2'd1,
        ACC_ACK   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [1:0] core;
    } acc_t;

    // Map a byte address onto a bank and a core index.
    function automatic acc_t decode_addr(
        input logic [31:0] addr,
        input logic [31:0] raise_base,
        input logic [31:0] ack_base,
        input int          ncores
    );
        acc_t        res;
        logic [31:0] off;
        logic [31:0] span;
        res.kind = ACC_NONE;
        res.core = 2'd0;
        off      = 32'd0;
        span     = 32'(ncores) * 32'd4;
        if (addr[1:0] == 2'b00) begin
            if (addr >= raise_base && addr < raise_base + span) begin
                off      = addr - raise_base;
                res.kind = ACC_RAISE;
                res.core = off[3:2];
            end else if (addr >= ack_base && addr < ack_base + span) begin
                off      = addr - ack_base;
                res.kind = ACC_ACK;
                res.core = off[3:2];
            end
        end
        return res;
    endfunction

    // Gather the sparse message bits of a bus word.
    function automatic logic [MAX_MSGS-1:0] gather_msgs(input logic [BUS_DW-1:0] w);
        logic [MAX_MSGS-1:0] m;
        for (int i = 0; i < MAX_MSGS; i++) begin
            m[i] = w[MSG_STRIDE*i];
        end
        return m;
    endfunction

    // Spread message bits back onto their sparse positions.
    function automatic logic [BUS_DW-1:0] spread_msgs(input logic [MAX_MSGS-1:0] m);
        logic [BUS_DW-1:0] w;
        w = '0;
        for (int i = 0; i < MAX_MSGS; i++) begin
            w[MSG_STRIDE*i] = m[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
    import ipi_pkg::*;
#(
    parameter int          NUM_CORES  = 4,
    parameter int          NUM_MSGS   = 4,
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] RAISE_BASE = 32'h70,
    parameter logic [31:0] ACK_BASE   = 32'h80,
    localparam int         VEC_W      = NUM_CORES * NUM_MSGS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BUS_DW-1:0] wdata,
    output logic [VEC_W-1:0]  raise_vec,
    output logic [VEC_W-1:0]  ack_vec
);

    acc_t                acc;
    logic [MAX_MSGS-1:0] msgs;

    always_comb begin
        acc  = decode_addr(32'(addr), RAISE_BASE, ACK_BASE, NUM_CORES);
        msgs = gather_msgs(wdata);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic hit;
        assign hit = we && (acc.core == 2'(c));
        assign raise_vec[c*NUM_MSGS +: NUM_MSGS] =
            (hit && acc.kind == ACC_RAISE) ? msgs[NUM_MSGS-1:0] : '0;
        assign ack_vec[c*NUM_MSGS +: NUM_MSGS] =
            (hit && acc.kind == ACC_ACK) ? msgs[NUM_MSGS-1:0] : '0;
    end

    // R8: a single port never reaches both banks in one access
    always_comb begin
        a_bank_exclusive_r8: assert (!((|raise_vec) && (|ack_vec)));
    end

endmodule

// File: rtl/ipi_pending_bank.sv
module ipi_pending_bank #(
    parameter int NUM_MSGS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_MSGS-1:0] raise_req,
    input  logic [NUM_MSGS-1:0] ack_req,
    output logic [NUM_MSGS-1:0] pend
);

    logic [NUM_MSGS-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_req) | raise_req;
        end
    end

    assign pend = pend_q;

    // R6: a raised bit is pending after the edge, whatever acknowledges arrived
    p_raise_wins_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((pend_q & $past(raise_req)) == $past(raise_req)));

    // R3: an acknowledged bit without a raise is clear after the edge
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((pend_q & $past(ack_req & ~raise_req)) == '0));

    // R2: no bit rises unless it was raised
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((pend_q & ~$past(pend_q) & ~$past(raise_req)) == '0));

endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port
    import ipi_pkg::*;
#(
    parameter int          NUM_CORES  = 4,
    parameter int          NUM_MSGS   = 4,
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] RAISE_BASE = 32'h70,
    parameter logic [31:0] ACK_BASE   = 32'h80,
    localparam int         VEC_W      = NUM_CORES * NUM_MSGS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [VEC_W-1:0]  pend_all,
    output logic [BUS_DW-1:0] rdata
);

    acc_t                acc;
    logic [MAX_MSGS-1:0] sel;

    always_comb begin
        acc = decode_addr(32'(addr), RAISE_BASE, ACK_BASE, NUM_CORES);
        sel = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (acc.kind == ACC_RAISE && acc.core == 2'(c)) begin
                sel[NUM_MSGS-1:0] = pend_all[c*NUM_MSGS +: NUM_MSGS];
            end
        end
        rdata = spread_msgs(sel);
    end

endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter int          NUM_PORTS  = 4,
    parameter int          NUM_CORES  = 4,
    parameter int          NUM_MSGS   = 4,
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] RAISE_BASE = 32'h70,
    parameter logic [31:0] ACK_BASE   = 32'h80
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS*ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PORTS-1:0]          bus_we,
    input  logic [NUM_PORTS*BUS_DW-1:0]   bus_wdata,
    output logic [NUM_PORTS*BUS_DW-1:0]   bus_rdata,
    output logic [NUM_CORES*NUM_MSGS-1:0] irq_out
);

    localparam int VEC_W = NUM_CORES * NUM_MSGS;

    logic [VEC_W-1:0] raise_p [NUM_PORTS];
    logic [VEC_W-1:0] ack_p   [NUM_PORTS];
    logic [VEC_W-1:0] raise_all;
    logic [VEC_W-1:0] ack_all;
    logic [VEC_W-1:0] pend_all;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ipi_port_decode #(
            .NUM_CORES (NUM_CORES),
            .NUM_MSGS  (NUM_MSGS),
            .ADDR_W    (ADDR_W),
            .RAISE_BASE(RAISE_BASE),
            .ACK_BASE  (ACK_BASE)
        ) u_dec (
            .addr     (bus_addr[p*ADDR_W +: ADDR_W]),
            .we       (bus_we[p]),
            .wdata    (bus_wdata[p*BUS_DW +: BUS_DW]),
            .raise_vec(raise_p[p]),
            .ack_vec  (ack_p[p])
        );

        ipi_read_port #(
            .NUM_CORES (NUM_CORES),
            .NUM_MSGS  (NUM_MSGS),
            .ADDR_W    (ADDR_W),
            .RAISE_BASE(RAISE_BASE),
            .ACK_BASE  (ACK_BASE)
        ) u_rd (
            .addr    (bus_addr[p*ADDR_W +: ADDR_W]),
            .pend_all(pend_all),
            .rdata   (bus_rdata[p*BUS_DW +: BUS_DW])
        );
    end

    // R7: merge the requests of all ports
    always_comb begin
        raise_all = '0;
        ack_all   = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            raise_all = raise_all | raise_p[p];
            ack_all   = ack_all | ack_p[p];
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
        ipi_pending_bank #(
            .NUM_MSGS(NUM_MSGS)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .raise_req(raise_all[c*NUM_MSGS +: NUM_MSGS]),
            .ack_req  (ack_all[c*NUM_MSGS +: NUM_MSGS]),
            .pend     (pend_all[c*NUM_MSGS +: NUM_MSGS])
        );
    end

    assign irq_out = pend_all;

    // R1: lines are low in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0));

    // R5: a line only moves in a cycle after some port wrote
    p_irq_needs_write_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(bus_we) == '0) |-> $stable(irq_out));

endmodule

// File: tb/ipi_ctrl_bench.sv
module ipi_ctrl_bench;

    localparam int NP = 4;
    localparam int NC = 4;
    localparam int NM = 4;
    localparam int AW = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NP*AW-1:0]   bus_addr;
    logic [NP-1:0]      bus_we;
    logic [NP*32-1:0]   bus_wdata;
    logic [NP*32-1:0]   bus_rdata;
    logic [NC*NM-1:0]   irq_out;

    logic [AW-1:0] p_addr [NP];
    logic          p_we   [NP];
    logic [31:0]   p_wd   [NP];
    logic [NM-1:0] model  [NC];

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            bus_addr[p*AW +: AW]  = p_addr[p];
            bus_we[p]             = p_we[p];
            bus_wdata[p*32 +: 32] = p_wd[p];
        end
    end

    ipi_ctrl #(
        .NUM_PORTS(NP), .NUM_CORES(NC), .NUM_MSGS(NM), .ADDR_W(AW)
    ) u_ipi_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] spread(input logic [NM-1:0] m);
        logic [31:0] w = '0;
        for (int i = 0; i < NM; i++) w[4*i] = m[i];
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        if (a[1:0] == 2'b00 && a >= 8'h70 && a < 8'h80)
            return spread(model[(a - 8'h70) >> 2]);
        return 32'h0;
    endfunction

    function automatic logic [NC*NM-1:0] exp_irq();
        logic [NC*NM-1:0] v;
        for (int c = 0; c < NC; c++) v[c*NM +: NM] = model[c];
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_ports();
        for (int p = 0; p < NP; p++) begin
            p_addr[p] = 8'h00;
            p_we[p]   = 1'b0;
            p_wd[p]   = 32'h0;
        end
    endtask

    task automatic drive(input int p, input logic [AW-1:0] a, input logic w, input logic [31:0] d);
        p_addr[p] = a;
        p_we[p]   = w;
        p_wd[p]   = d;
    endtask

    // Called at a falling edge with ports driven; checks reads, advances one edge, checks lines.
    task automatic step();
        logic [NM-1:0] rs [NC];
        logic [NM-1:0] cl [NC];
        #1;
        for (int p = 0; p < NP; p++)
            check("R4 read data", bus_rdata[p*32 +: 32], exp_read(p_addr[p]));
        for (int c = 0; c < NC; c++) begin
            rs[c] = '0;
            cl[c] = '0;
        end
        for (int p = 0; p < NP; p++) begin
            if (p_we[p] && p_addr[p][1:0] == 2'b00) begin
                logic [NM-1:0] m = '0;
                for (int i = 0; i < NM; i++) m[i] = p_wd[p][4*i];
                if (p_addr[p] >= 8'h70 && p_addr[p] < 8'h80)
                    rs[(p_addr[p] - 8'h70) >> 2] |= m;
                else if (p_addr[p] >= 8'h80 && p_addr[p] < 8'h90)
                    cl[(p_addr[p] - 8'h80) >> 2] |= m;
            end
        end
        for (int c = 0; c < NC; c++) model[c] = (model[c] & ~cl[c]) | rs[c];
        @(negedge clk);
        check("R5 irq levels", 32'(irq_out), 32'(exp_irq()));
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int k = $urandom % 10;
        int c = $urandom % 4;
        case (k)
            0, 1, 2, 3: return 8'(8'h70 + 4*c);
            4, 5, 6:    return 8'(8'h80 + 4*c);
            7:          return 8'(8'h90 + 4*c);
            8:          return 8'(8'h70 + 4*c + 1 + ($urandom % 3));
            default:    return 8'($urandom);
        endcase
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        idle_ports();
        for (int c = 0; c < NC; c++) model[c] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 irq after reset", 32'(irq_out), 32'h0);
        drive(0, 8'h70, 1'b0, 32'h0);
        drive(1, 8'h7C, 1'b0, 32'h0);
        #1;
        check("R1 read after reset", bus_rdata[31:0], 32'h0);
        check("R1 read after reset", bus_rdata[63:32], 32'h0);

        // R2: raise messages 0 and 2 at core 2
        idle_ports();
        drive(0, 8'h78, 1'b1, 32'h0000_0101);
        step();
        check("R2 core2 lines", 32'(irq_out[11:8]), 32'h5);
        idle_ports();
        drive(3, 8'h78, 1'b0, 32'h0);
        #1;
        check("R4 core2 read", bus_rdata[127:96], 32'h0000_0101);

        // R2: zero bits keep existing state, OR with message 1
        idle_ports();
        drive(1, 8'h78, 1'b1, 32'h0000_0010);
        step();
        check("R2 or into pending", 32'(irq_out[11:8]), 32'h7);

        // R3: acknowledge message 0
        idle_ports();
        drive(0, 8'h88, 1'b1, 32'h0000_0001);
        step();
        check("R3 ack clears", 32'(irq_out[11:8]), 32'h6);

        // R6 and R7: raise and ack of msg3 together, ack of msg1 from another port
        idle_ports();
        drive(0, 8'h78, 1'b1, 32'h0000_1000);
        drive(1, 8'h88, 1'b1, 32'h0000_1000);
        drive(2, 8'h88, 1'b1, 32'h0000_0010);
        step();
        check("R6 raise wins", 32'(irq_out[11]), 32'h1);
        check("R7 merged ports", 32'(irq_out[11:8]), 32'hC);

        // R8: out-of-range core, unaligned and stray addresses
        idle_ports();
        drive(0, 8'h90, 1'b1, 32'hFFFF_FFFF);
        drive(1, 8'h7A, 1'b1, 32'hFFFF_FFFF);
        drive(2, 8'h60, 1'b1, 32'hFFFF_FFFF);
        drive(3, 8'h8D, 1'b1, 32'hFFFF_FFFF);
        step();
        check("R8 ignored writes", 32'(irq_out), 32'h0C00);

        // R9: only bits 4*m count
        idle_ports();
        drive(0, 8'h7C, 1'b1, 32'hEEEE_EEEE);
        step();
        check("R9 gap bits ignored", 32'(irq_out), 32'h0C00);
        idle_ports();
        drive(0, 8'h7C, 1'b1, 32'hFFFF_FFFF);
        step();
        check("R9 all messages", 32'(irq_out[15:12]), 32'hF);
        idle_ports();
        drive(2, 8'h7C, 1'b0, 32'h0);
        drive(1, 8'h8C, 1'b0, 32'h0);
        #1;
        check("R4 sparse read", bus_rdata[95:64], 32'h0000_1111);
        check("R4 ack bank reads zero", bus_rdata[63:32], 32'h0);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            idle_ports();
            for (int p = 0; p < NP; p++) begin
                logic [31:0] d = ($urandom % 2) ? spread(NM'($urandom)) : $urandom;
                drive(p, pick_addr(), ($urandom % 3) != 0, d);
            end
            step();
        end

        // R1: reset mid-run clears everything
        idle_ports();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NC; c++) model[c] = '0;
        check("R1 irq after second reset", 32'(irq_out), 32'h0);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule